// File: doc/BRIEF.md
# Two-Frame TDM Elastic Store

This block carries E1 or T1 frame data from a line clock domain into an unrelated system clock domain. The line side writes one byte per strobe, with a marker on the first byte of each frame. The system side pulls one byte per strobe, aligned to its own frame marker, and gets each byte back one cycle later. Storage is two frames deep. One frame half is read while the other is filled.

Frame boundaries are the only points where the read side changes frame half. When the two clocks drift apart, the read side either repeats or drops a whole frame, never part of one. Each such slip raises a sticky flag for its direction, and a one-cycle event pulse that a signalling path can use to freeze its bits. In T1 mode a 24-channel line frame is spread over a 32-slot system frame. The line framing bit can optionally ride in slot 0, and unused slots carry a programmable idle byte.

Top module: `elasticStore`

## Requirements
- R1: Each system read strobe (`rdEn`) produces `rdValid` with one byte on `rdData` exactly one `rdClk` cycle later. A strobe with `rdSync` high is slot 0, and each later strobe is the next slot. In E1 mode, slot n of a read frame returns byte n of the most recently completed line frame.
- R2: A line frame counts as complete only when the next line frame marker arrives. Until the first line frame has completed after reset, every read byte equals `idleByte`, and no slip is flagged.
- R3: If no new line frame has completed since the last read frame start, the next read frame repeats the previous frame in full. This sets `slipRepeat`, which then stays set.
- R4: If two or more line frames have completed since the last read frame start, the older ones are skipped and the newest is read. This sets `slipDelete`, which then stays set.
- R5: Every slip produces exactly one `slipEvent` pulse, one `rdClk` cycle long, in the cycle after the read frame start that slipped.
- R6: `slipClr[0]` clears `slipRepeat` and `slipClr[1]` clears `slipDelete`, acting in the next cycle. A slip in the same cycle wins over the clear. Both flags are 0 after reset.
- R7: With `t1Mode` = 1, a line frame is 24 bytes. System slot k (1..24) carries line byte k-1, and slots 25..31 carry `idleByte`.
- R8: With `t1Mode` = 1, slot 0 carries the framing bit captured with that frame's first byte. The framing bit is placed in bit 7, with bits 6..0 set to 1, when `fbitPass` = 1. When `fbitPass` = 0, slot 0 carries `idleByte`.
- R9: Line bytes written after the frame length (32 in E1 mode, 24 in T1 mode) and before the next marker are dropped. They do not alter any stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Line-side clock |
| wrRstN | input | 1 | Line-side reset, active low |
| wrValid | input | 1 | Line byte strobe |
| wrSync | input | 1 | Marks first byte of a line frame |
| wrData | input | 8 | Line byte |
| wrFbit | input | 1 | T1 framing bit, sampled with the first byte |
| rdClk | input | 1 | System-side clock |
| rdRstN | input | 1 | System-side reset, active low |
| rdEn | input | 1 | System slot strobe |
| rdSync | input | 1 | Marks slot 0 of a system frame |
| t1Mode | input | 1 | 1: 24-channel line frame mapped into 32 slots |
| fbitPass | input | 1 | 1: carry framing bit in slot 0 (T1 mode) |
| idleByte | input | 8 | Fill byte for unused or not-yet-valid slots |
| slipClr | input | 2 | Write-one-to-clear: bit 0 repeat flag, bit 1 delete flag |
| rdData | output | 8 | System byte |
| rdValid | output | 1 | rdData valid |
| slipRepeat | output | 1 | Sticky: a frame was repeated |
| slipDelete | output | 1 | Sticky: a frame was dropped |
| slipEvent | output | 1 | One-cycle pulse per slip |

## Verification
The bench reads before any frame has completed. A store that trusted the first line marker would return stale memory instead of idle bytes, or would flag a bogus repeat. It then starves the reader, expecting a complete replay of the prior frame; a design slipping mid-frame would mix frames. It also floods the writer so that two frames complete between reads, where a wrong design reads the stale half or fails to flag a delete. Line frames longer than their mode allows are written, which catches a slot counter that wraps over slot 0. The T1 slot map is checked with the framing bit both passed and suppressed.

// File: rtl/es_pkg.sv
package es_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_FBIT = 2'd2
  } srcSel_t;

  typedef struct packed {
    logic we;
    logic half;
  } wrCmd_t;

  typedef struct packed {
    logic    fire;
    logic    half;
    srcSel_t src;
  } rdCmd_t;

endpackage

// File: rtl/esCtrl.sv
module esCtrl
  import es_pkg::*;
#(
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned T1_CHANS = 24,
  localparam int unsigned SW = $clog2(E1_SLOTS),
  localparam int unsigned CW = $clog2(E1_SLOTS + 1)
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrValid,
  input  logic          wrSync,
  input  logic          t1Mode,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEn,
  input  logic          rdSync,
  input  logic          fbitPass,
  input  logic [1:0]    slipClr,
  output wrCmd_t        wrCmd,
  output logic [SW-1:0] wrSlot,
  output rdCmd_t        rdCmd,
  output logic [SW-1:0] rdChan,
  output logic          slipRepeat,
  output logic          slipDelete,
  output logic          slipEvent
);

  localparam logic [CW-1:0] SLOT_END = CW'(E1_SLOTS);
  localparam logic [CW-1:0] T1_END   = CW'(T1_CHANS);

  // ---------------- line side ----------------
  logic [CW-1:0] wrSlotQ;
  logic          wrHalf;
  logic          wrSeen;
  logic [CW-1:0] curWrSlot;
  logic [CW-1:0] wrLen;

  assign wrLen     = t1Mode ? T1_END : SLOT_END;
  assign curWrSlot = wrSync ? '0 : wrSlotQ;

  always_comb begin
    wrCmd.we   = wrValid && (wrSync || wrSeen) && (curWrSlot < wrLen);
    wrCmd.half = (wrSync && wrSeen) ? ~wrHalf : wrHalf;
    wrSlot     = SW'(curWrSlot);
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrSlotQ <= '0;
      wrHalf  <= 1'b0;
      wrSeen  <= 1'b0;
    end else if (wrValid) begin
      if (wrSync) begin
        if (wrSeen) wrHalf <= ~wrHalf;
        wrSeen  <= 1'b1;
        wrSlotQ <= CW'(1);
      end else if (wrSlotQ != SLOT_END) begin
        wrSlotQ <= wrSlotQ + CW'(1);
      end
    end
  end

  // ---------------- system side ----------------
  logic          halfS1, halfS2, halfP;
  logic          doneEv;
  logic [1:0]    credit, creditInc, nxtCredit;
  logic          rdHalf, nxtHalf;
  logic          rdStarted, nxtStarted;
  logic          repNow, delNow;
  logic          frameStart;
  logic [CW-1:0] rdSlotQ;
  logic [CW-1:0] curSlot;

  assign doneEv     = halfS2 ^ halfP;
  assign frameStart = rdEn && rdSync;
  assign curSlot    = rdSync ? '0 : rdSlotQ;
  assign creditInc  = (credit == 2'd3) ? credit : credit + {1'b0, doneEv};

  always_comb begin
    nxtHalf    = rdHalf;
    nxtStarted = rdStarted;
    nxtCredit  = creditInc;
    repNow     = 1'b0;
    delNow     = 1'b0;
    if (frameStart) begin
      nxtCredit = 2'd0;
      if (creditInc == 2'd0) begin
        repNow = rdStarted;
      end else begin
        nxtHalf    = ~halfS2;
        nxtStarted = 1'b1;
        delNow     = (creditInc >= 2'd2);
      end
    end
  end

  always_comb begin
    rdCmd.fire = rdEn;
    rdCmd.half = nxtHalf;
    rdCmd.src  = SRC_IDLE;
    rdChan     = '0;
    if (nxtStarted && (curSlot < SLOT_END)) begin
      if (t1Mode) begin
        if (curSlot == '0) begin
          rdCmd.src = fbitPass ? SRC_FBIT : SRC_IDLE;
        end else if (curSlot <= T1_END) begin
          rdCmd.src = SRC_MEM;
          rdChan    = SW'(curSlot - CW'(1));
        end
      end else begin
        rdCmd.src = SRC_MEM;
        rdChan    = SW'(curSlot);
      end
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      halfS1     <= 1'b0;
      halfS2     <= 1'b0;
      halfP      <= 1'b0;
      credit     <= 2'd0;
      rdHalf     <= 1'b0;
      rdStarted  <= 1'b0;
      rdSlotQ    <= '0;
      slipRepeat <= 1'b0;
      slipDelete <= 1'b0;
      slipEvent  <= 1'b0;
    end else begin
      halfS1     <= wrHalf;
      halfS2     <= halfS1;
      halfP      <= halfS2;
      credit     <= nxtCredit;
      rdHalf     <= nxtHalf;
      rdStarted  <= nxtStarted;
      if (rdEn) rdSlotQ <= (curSlot == SLOT_END) ? curSlot : curSlot + CW'(1);
      slipRepeat <= repNow | (slipRepeat & ~slipClr[0]);
      slipDelete <= delNow | (slipDelete & ~slipClr[1]);
      slipEvent  <= repNow | delNow;
    end
  end

  // R3: a repeat can only be flagged once data has been flowing
  a_r3_repeat_needs_data: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(slipRepeat) |-> $past(rdStarted));
  // R5: an event pulse is always backed by a sticky flag
  a_r5_event_has_flag: assert property (@(posedge rdClk) disable iff (!rdRstN)
    slipEvent |-> (slipRepeat || slipDelete));
  // R6: clear without concurrent slip drops the repeat flag
  a_r6_clear_repeat: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (slipClr[0] && !repNow) |=> !slipRepeat);
  // R2: no delete slip is reported before the first frame was taken
  a_r2_no_early_delete: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(slipDelete) |-> $past(nxtStarted));

endmodule

// File: rtl/esData.sv
module esData
  import es_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned E1_SLOTS = 32,
  localparam int unsigned SW    = $clog2(E1_SLOTS),
  localparam int unsigned DEPTH = 2 * E1_SLOTS,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  wrCmd_t            wrCmd,
  input  logic [SW-1:0]     wrSlot,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrFbit,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  rdCmd_t            rdCmd,
  input  logic [SW-1:0]     rdChan,
  input  logic [DATA_W-1:0] idleByte,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [1:0]        fbitQ;
  logic [AW-1:0]     wrAddr, rdAddr;

  assign wrAddr = wrCmd.half ? AW'(wrSlot) + AW'(E1_SLOTS) : AW'(wrSlot);
  assign rdAddr = rdCmd.half ? AW'(rdChan) + AW'(E1_SLOTS) : AW'(rdChan);

  always_ff @(posedge wrClk) begin
    if (wrCmd.we) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      fbitQ <= 2'b00;
    end else if (wrCmd.we && (wrSlot == '0)) begin
      fbitQ[wrCmd.half] <= wrFbit;
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdCmd.fire;
      if (rdCmd.fire) begin
        unique case (rdCmd.src)
          SRC_MEM:  rdData <= mem[rdAddr];
          SRC_FBIT: rdData <= {fbitQ[rdCmd.half], {(DATA_W-1){1'b1}}};
          default:  rdData <= idleByte;
        endcase
      end
    end
  end

  // R1: one output byte per strobe, one cycle later
  a_r1_valid_latency: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdCmd.fire |=> rdValid);
  a_r1_valid_only_on_strobe: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdCmd.fire |=> !rdValid);
  // R8: framing-bit slot keeps its low bits set
  a_r8_fbit_shape: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdCmd.fire && rdCmd.src == SRC_FBIT) |=> (rdData[DATA_W-2:0] == {(DATA_W-1){1'b1}}));

endmodule

// File: rtl/elasticStore.sv
module elasticStore
  import es_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned T1_CHANS = 24
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrValid,
  input  logic              wrSync,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrFbit,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  input  logic              rdSync,
  input  logic              t1Mode,
  input  logic              fbitPass,
  input  logic [DATA_W-1:0] idleByte,
  input  logic [1:0]        slipClr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              slipRepeat,
  output logic              slipDelete,
  output logic              slipEvent
);

  localparam int unsigned SW = $clog2(E1_SLOTS);

  wrCmd_t        wrCmd;
  rdCmd_t        rdCmd;
  logic [SW-1:0] wrSlot;
  logic [SW-1:0] rdChan;

  esCtrl #(.E1_SLOTS(E1_SLOTS), .T1_CHANS(T1_CHANS)) ctrl_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrSync(wrSync),
    .t1Mode(t1Mode), .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .rdSync(rdSync), .fbitPass(fbitPass), .slipClr(slipClr),
    .wrCmd(wrCmd), .wrSlot(wrSlot), .rdCmd(rdCmd), .rdChan(rdChan),
    .slipRepeat(slipRepeat), .slipDelete(slipDelete), .slipEvent(slipEvent)
  );

  esData #(.DATA_W(DATA_W), .E1_SLOTS(E1_SLOTS)) data_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrCmd(wrCmd), .wrSlot(wrSlot),
    .wrData(wrData), .wrFbit(wrFbit), .rdClk(rdClk), .rdRstN(rdRstN),
    .rdCmd(rdCmd), .rdChan(rdChan), .idleByte(idleByte),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/elasticStore_tb_top.sv
module elasticStore_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 32;
  localparam int T1LEN      = 24;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0, wrSync = 1'b0, wrFbit = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0, rdSync = 1'b0;
  logic       t1Mode = 1'b0, fbitPass = 1'b0;
  logic [7:0] idleByte = 8'hFF;
  logic [1:0] slipClr = 2'b00;
  logic [7:0] rdData;
  logic       rdValid, slipRepeat, slipDelete, slipEvent;

  int tests = 0;
  int fails = 0;
  int evCount = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  // bench model of the requirements
  int  mCredit, mLastDone, mCurWr, mLastRead, mEvents;
  bit  mSeen, mStarted, mRep, mDel;

  always #(CLK_PERIOD/2) clk = ~clk;

  elasticStore dut_i (
    .wrClk(clk), .wrRstN(rstN), .wrValid(wrValid), .wrSync(wrSync),
    .wrData(wrData), .wrFbit(wrFbit), .rdClk(clk), .rdRstN(rstN),
    .rdEn(rdEn), .rdSync(rdSync), .t1Mode(t1Mode), .fbitPass(fbitPass),
    .idleByte(idleByte), .slipClr(slipClr), .rdData(rdData),
    .rdValid(rdValid), .slipRepeat(slipRepeat), .slipDelete(slipDelete),
    .slipEvent(slipEvent)
  );

  function automatic logic [7:0] fb(int id, int s);
    return 8'((id * 16 + s * 3 + 1) & 255);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every produced byte with the scoreboard
  always @(negedge clk) begin
    if (rstN && slipEvent) evCount++;
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected byte", int'(rdData), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, int'(rdData), int'(e));
      end
    end
  end

  task automatic resetAll();
    rstN = 1'b0;
    mCredit = 0; mSeen = 0; mStarted = 0; mRep = 0; mDel = 0;
    mLastDone = 0; mCurWr = 0; mLastRead = 0; mEvents = 0;
    repeat (3) @(negedge clk);
    evCount = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeFrame(int id, int len);
    for (int s = 0; s < len; s++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrSync  = (s == 0);
      wrData  = fb(id, s);
      wrFbit  = id[0];
    end
    @(negedge clk);
    wrValid = 1'b0; wrSync = 1'b0;
    repeat (6) @(negedge clk);
    if (mSeen) begin
      if (mCredit < 3) mCredit++;
      mLastDone = mCurWr;
    end
    mSeen = 1;
    mCurWr = id;
  endtask

  task automatic readFrame(string tag);
    int  id;
    bit  live;
    bit  rep, del;
    rep = 0; del = 0; id = 0;
    if (mCredit == 0) begin
      rep = mStarted;
      id  = mLastRead;
    end else begin
      del = (mCredit >= 2);
      id  = mLastDone;
      mStarted = 1;
      mLastRead = id;
    end
    mCredit = 0;
    live = mStarted;
    if (rep || del) mEvents++;
    mRep = mRep | rep;
    mDel = mDel | del;
    for (int s = 0; s < SLOTS; s++) begin
      logic [7:0] e;
      if (!live) e = idleByte;
      else if (!t1Mode) e = fb(id, s);
      else if (s == 0) e = fbitPass ? {id[0], 7'h7F} : idleByte;
      else if (s <= T1LEN) e = fb(id, s - 1);
      else e = idleByte;
      expQ.push_back(e);
      tagQ.push_back($sformatf("%s slot %0d", tag, s));
    end
    for (int s = 0; s < SLOTS; s++) begin
      @(negedge clk);
      rdEn = 1'b1;
      rdSync = (s == 0);
    end
    @(negedge clk);
    rdEn = 1'b0; rdSync = 1'b0;
    repeat (3) @(negedge clk);
    check(slipRepeat == mRep, {tag, " R3 repeat flag"}, int'(slipRepeat), int'(mRep));
    check(slipDelete == mDel, {tag, " R4 delete flag"}, int'(slipDelete), int'(mDel));
    check(evCount == mEvents, {tag, " R5 event count"}, evCount, mEvents);
  endtask

  task automatic clearFlags(logic [1:0] which);
    @(negedge clk);
    slipClr = which;
    @(negedge clk);
    slipClr = 2'b00;
    if (which[0]) mRep = 0;
    if (which[1]) mDel = 0;
    check(slipRepeat == mRep, "R6 repeat after clear", int'(slipRepeat), int'(mRep));
    check(slipDelete == mDel, "R6 delete after clear", int'(slipDelete), int'(mDel));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    resetAll();
    // reset state
    check(rdValid == 1'b0, "R1 reset rdValid", int'(rdValid), 0);
    check(slipRepeat == 1'b0, "R6 reset repeat flag", int'(slipRepeat), 0);
    check(slipDelete == 1'b0, "R6 reset delete flag", int'(slipDelete), 0);

    // R2: nothing written, then one frame begun but not completed
    readFrame("R2 empty");
    writeFrame(1, SLOTS);
    readFrame("R2 first frame open");

    // R1: normal flow
    writeFrame(2, SLOTS);
    readFrame("R1 frame1");
    writeFrame(3, SLOTS);
    readFrame("R1 frame2");

    // R3: reader starved
    readFrame("R3 repeat");
    clearFlags(2'b01);

    // R4: writer ahead by two frames
    writeFrame(4, SLOTS);
    writeFrame(5, SLOTS);
    readFrame("R4 delete");
    clearFlags(2'b10);

    // R9: overlong line frame must not wrap over its own start
    writeFrame(6, SLOTS + 3);
    readFrame("R9 before long");
    writeFrame(7, SLOTS);
    readFrame("R9 long frame");

    // R7 / R8: T1 mapping with framing bit passed, then suppressed
    resetAll();
    t1Mode = 1'b1; fbitPass = 1'b1; idleByte = 8'h5A;
    writeFrame(10, T1LEN);
    writeFrame(11, T1LEN + 2);
    readFrame("R7 R8 t1 fbit even");
    writeFrame(12, T1LEN);
    readFrame("R7 R8 R9 t1 fbit odd");
    fbitPass = 1'b0;
    writeFrame(13, T1LEN);
    readFrame("R8 t1 no fbit");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R1 all expected bytes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule